// File: doc/BRIEF.md
# Indexed Block Register Target on a Two-Wire Serial Bus

This block is a bus target on a two-wire serial bus. It gives a host read and write access to a small bank of 8-bit configuration registers. The block samples the clock and data lines with its own system clock. It finds start, repeated-start and stop conditions from data-line edges that occur while the clock line is high. It answers one fixed 7-bit device address, 0x69. The address byte is 0xD2 for a write and 0xD3 for a read. The block pulls the data line low only to acknowledge or to send a zero bit, so the line behaves as open drain.

In a write transfer, the host sends a starting index and then a byte count. The data bytes follow and fill consecutive registers. In a read transfer, the host first writes the index. It then issues a repeated start with the read address. The block answers with a count byte, followed by register contents from that index upwards.

The surrounding logic sees every register in parallel on a flat bus. It also sees each accepted write as a one-cycle strobe that carries the register number and the value.

Top module: `smb_regblock_tgt`

## Requirements
- R1: A write transfer (start, 0xD2, index N, count X, X data bytes, stop) stores the data bytes into registers N, N+1, …, N+X-1 in order. Each byte is taken most significant bit first. Register k appears on `cfg_q[8k+7:8k]`.
- R2: The block acknowledges the address byte of a matching transfer, the index byte, the count byte, and every data byte that falls within the count. It acknowledges by holding the data line low during the ninth clock of the byte.
- R3: After a repeated start with 0xD3, the block first sends a count byte. The count byte equals NREGS-N when the index N is below NREGS, and 0 otherwise. The block then sends register N, N+1, and so on, most significant bit first. The index advances by one for each data byte sent.
- R4: When the host answers a sent byte with a NACK, the block releases the data line. It drives nothing more until the next start.
- R5: The block leaves an address byte whose upper seven bits differ from 0x69 unacknowledged. The block then stays silent and changes no register until the next start.
- R6: A data byte whose index is NREGS or above is acknowledged but changes no register. A read at such an index returns 0x00.
- R7: Once X data bytes of a write have been taken, further data bytes are not acknowledged and are not stored. This also holds when X is 0.
- R8: A stop returns the block to idle from any state, with the data line released. A later transfer then works normally.
- R9: A repeated start in any state, including the middle of a write or after a foreign address, restarts address matching.
- R10: The block changes the level it drives on the data line only while the clock line is low.
- R11: After reset, all registers hold 0x00 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cfg_q | output | NREGS*8 | All registers, register k at bits 8k+7:8k |
| wr_stb | output | 1 | One-cycle pulse for each stored data byte |
| wr_idx | output | $clog2(NREGS) | Register number of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
The bench builds the block with NREGS=6, which is not a power of two. With this value the index values 6 and 7 fall outside the bank but stay inside the decoded index range. It sweeps every start index and every count that fits, and models the bank as an array. It then reads back every start index from 0 to 7. This covers count bytes of 0 and reads that run past the last register. Foreign addresses, an early NACK, count overrun, and stops and repeated starts in the middle of a transfer are each driven as separate cases.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    PH_ADDR, PH_IDX, PH_CNT, PH_WDAT, PH_RCNT, PH_RDAT
  } phase_e;

  function automatic logic idx_ok(input logic [7:0] idx, input int n);
    return int'(idx) < n;
  endfunction

  function automatic logic [7:0] rd_count(input logic [7:0] idx, input int n);
    return (int'(idx) < n) ? 8'(n - int'(idx)) : 8'h00;
  endfunction

  function automatic logic addr_match(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_i};
      sda_ff <= {sda_ff[0], sda_i};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
  parameter int NREGS = 8,
  localparam int IDXW = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDXW-1:0]   waddr,
  input  logic [7:0]        wdata,
  input  logic [IDXW-1:0]   raddr,
  output logic [7:0]        rdata,
  output logic [NREGS*8-1:0] flat_q
);
  logic [7:0] mem [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= 8'h00;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar g = 0; g < NREGS; g++) begin : g_flat
    assign flat_q[g*8 +: 8] = mem[g];
  end
endmodule

// File: rtl/smb_regblock_tgt.sv
module smb_regblock_tgt
  import smb_pkg::*;
#(
  parameter int         NREGS    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IDXW     = $clog2(NREGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [NREGS*8-1:0] cfg_q,
  output logic               wr_stb,
  output logic [IDXW-1:0]    wr_idx,
  output logic [7:0]         wr_data
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  smb_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  phase_e     phase;
  logic       act, ack_slot, host_ack;
  logic [3:0] bitcnt;
  logic [7:0] rx_sh, tx_sh, idx, cnt_left;
  logic [7:0] rf_rdata, rd_byte, tx_next;
  logic       tx_phase, byte_end, addr_done, addr_hit;

  smb_regfile #(.NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(wr_stb), .waddr(wr_idx), .wdata(wr_data),
    .raddr(idx[IDXW-1:0]), .rdata(rf_rdata), .flat_q(cfg_q)
  );

  assign tx_phase  = (phase == PH_RCNT) || (phase == PH_RDAT);
  assign rd_byte   = idx_ok(idx, NREGS) ? rf_rdata : 8'h00;
  assign tx_next   = (phase == PH_RCNT) ? rd_count(idx, NREGS) : rd_byte;
  assign byte_end  = act && scl_fall && !ack_slot && (bitcnt == 4'd8);
  assign addr_done = byte_end && (phase == PH_ADDR);
  assign addr_hit  = addr_match(rx_sh, DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; ack_slot <= 1'b0; host_ack <= 1'b0; sda_oe <= 1'b0;
      phase <= PH_ADDR; bitcnt <= '0; rx_sh <= '0; tx_sh <= '0;
      idx <= '0; cnt_left <= '0; wr_stb <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        act <= 1'b1; phase <= PH_ADDR; bitcnt <= '0;
        ack_slot <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        act <= 1'b0; ack_slot <= 1'b0; sda_oe <= 1'b0;
      end else if (act && scl_rise) begin
        if (ack_slot) begin
          if (tx_phase) host_ack <= ~sda_s;
        end else if (bitcnt < 4'd8) begin
          rx_sh  <= {rx_sh[6:0], sda_s};
          bitcnt <= bitcnt + 4'd1;
        end
      end else if (act && scl_fall) begin
        if (ack_slot) begin
          ack_slot <= 1'b0;
          bitcnt   <= '0;
          if (tx_phase && host_ack) begin
            tx_sh  <= tx_next;
            sda_oe <= ~tx_next[7];
            if (phase == PH_RCNT) phase <= PH_RDAT;
            else idx <= idx + 8'd1;
          end else begin
            sda_oe <= 1'b0;
            if (tx_phase) act <= 1'b0;
          end
        end else if (bitcnt == 4'd8) begin
          ack_slot <= 1'b1;
          sda_oe   <= 1'b0;
          unique case (phase)
            PH_ADDR: begin
              if (addr_hit) begin
                sda_oe   <= 1'b1;
                host_ack <= 1'b1;
                phase    <= rx_sh[0] ? PH_RCNT : PH_IDX;
              end else begin
                act <= 1'b0;
              end
            end
            PH_IDX: begin
              idx <= rx_sh; sda_oe <= 1'b1; phase <= PH_CNT;
            end
            PH_CNT: begin
              cnt_left <= rx_sh; sda_oe <= 1'b1; phase <= PH_WDAT;
            end
            PH_WDAT: begin
              if (cnt_left != 8'd0) begin
                sda_oe   <= 1'b1;
                cnt_left <= cnt_left - 8'd1;
                wr_stb   <= idx_ok(idx, NREGS);
                wr_idx   <= idx[IDXW-1:0];
                wr_data  <= rx_sh;
                idx      <= idx + 8'd1;
              end
            end
            default: ;
          endcase
        end else if (tx_phase) begin
          sda_oe <= ~tx_sh[3'(4'd7 - bitcnt)];
        end
      end
    end
  end
endmodule

// File: rtl/smb_regblock_chk.sv
module smb_regblock_chk #(
  parameter int NREGS = 8,
  localparam int IDXW = $clog2(NREGS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_s,
  input logic            sda_oe,
  input logic            start_evt,
  input logic            stop_evt,
  input logic            addr_done,
  input logic            addr_hit,
  input logic            wr_stb,
  input logic [IDXW-1:0] wr_idx
);
  p_drive_moves_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  p_stop_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  p_restart_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  p_foreign_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && !addr_hit) |=> !sda_oe);

  p_own_addr_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_done && addr_hit) |=> sda_oe);

  p_store_in_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (int'(wr_idx) < NREGS));
endmodule

bind smb_regblock_tgt smb_regblock_chk #(.NREGS(NREGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .addr_done(addr_done),
  .addr_hit(addr_hit), .wr_stb(wr_stb), .wr_idx(wr_idx)
);

// File: tb/smb_regblock_tgt_tb_top.sv
module smb_regblock_tgt_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 6;
  localparam int Q  = 6;
  localparam int IW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_h = 1'b1;
  logic sda_oe, wr_stb, sda_line;
  logic [NR*8-1:0] cfg_q;
  logic [IW-1:0] wr_idx;
  logic [7:0] wr_data;
  logic [7:0] model [NR];
  int errors = 0, checks = 0, drive_viol = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  smb_regblock_tgt #(.NREGS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_q(cfg_q), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (rst_n && prev_scl && scl && (sda_oe != prev_oe)) drive_viol++;
    prev_oe  = sda_oe;
    prev_scl = scl;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_h = 1'b1; qw(); scl = 1'b1; qw(); sda_h = 1'b0; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; qw(); scl = 1'b1; qw(); sda_h = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; qw(); scl = 1'b1; qw(); scl = 1'b0; qw();
    end
    sda_h = 1'b1; qw(); scl = 1'b1; qw(); ack = ~sda_line; scl = 1'b0; qw();
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; scl = 1'b0;
    end
    qw(); sda_h = ~give_ack; qw(); scl = 1'b1; qw(); scl = 1'b0; qw(); sda_h = 1'b1;
  endtask

  function automatic logic [7:0] pat(input int n, input int k, input int x);
    return 8'((n * 37) ^ (k * 73) ^ (x * 5) ^ 8'hA5);
  endfunction

  task automatic chk_bank(input string rq);
    logic [NR*8-1:0] exp;
    for (int i = 0; i < NR; i++) exp[i*8 +: 8] = model[i];
    chk(cfg_q == exp, rq, int'(cfg_q), int'(exp));
  endtask

  task automatic wr_txn(input int n, input int x, input int nsend, input string rq);
    bit a, ok;
    logic [7:0] d;
    ok = 1'b1;
    bus_start();
    send_byte(8'hD2, a); ok &= a;
    send_byte(8'(n), a); ok &= a;
    send_byte(8'(x), a); ok &= a;
    for (int k = 0; k < nsend; k++) begin
      d = pat(n, k, x);
      send_byte(d, a);
      ok &= (a == (k < x));
      if (k < x && n + k < NR) model[n + k] = d;
    end
    bus_stop();
    chk(ok, "R2 ack pattern", int'(ok), 1);
    chk_bank(rq);
  endtask

  task automatic rd_txn(input int n, input int nrecv, input string rq);
    bit a;
    logic [7:0] b, e;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2 addr ack", int'(a), 1);
    send_byte(8'(n), a);
    bus_start();
    send_byte(8'hD3, a); chk(a, "R3 read addr ack", int'(a), 1);
    recv_byte(b, nrecv > 0);
    e = (n < NR) ? 8'(NR - n) : 8'h00;
    chk(b == e, "R3 count byte", int'(b), int'(e));
    for (int k = 0; k < nrecv; k++) begin
      recv_byte(b, k < nrecv - 1);
      e = (n + k < NR) ? model[n + k] : 8'h00;
      chk(b == e, rq, int'(b), int'(e));
    end
    bus_stop();
  endtask

  initial begin
    repeat (200000 - 1000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    qw();
    chk(sda_oe == 1'b0, "R11 released", int'(sda_oe), 0);
    chk_bank("R11 bank zero");

    for (int n = 0; n < NR; n++)
      for (int x = 1; x <= NR - n; x++) wr_txn(n, x, x, "R1 write sweep");

    for (int n = 0; n < NR + 2; n++) rd_txn(n, (n < NR) ? NR - n + 1 : 2, "R3/R6 read data");

    wr_txn(NR, 2, 2, "R6 out of range write");
    wr_txn(NR - 1, 3, 3, "R6 partial range write");
    wr_txn(0, 1, 3, "R7 overrun");
    wr_txn(2, 0, 1, "R7 zero count");

    // R5 foreign address, write then read
    bus_start();
    send_byte(8'hA4, a); chk(!a, "R5 no addr ack", int'(a), 0);
    send_byte(8'h01, a); chk(!a, "R5 silent", int'(a), 0);
    send_byte(8'h77, a); chk(!a, "R5 silent data", int'(a), 0);
    bus_stop();
    chk_bank("R5 bank unchanged");
    bus_start();
    send_byte(8'hD5, a); chk(!a, "R5 read addr", int'(a), 0);
    recv_byte(b, 1'b0); chk(b == 8'hFF, "R5 no drive", int'(b), 8'hFF);
    bus_stop();

    // R4 host NACK on count byte
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a);
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(b, 1'b0); chk(b == 8'(NR), "R4 count", int'(b), NR);
    recv_byte(b, 1'b0); chk(b == 8'hFF, "R4 released after NACK", int'(b), 8'hFF);
    bus_stop();

    // R9 repeated start mid-write and after a foreign address
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h01, a); send_byte(8'h03, a);
    send_byte(8'h3C, a); model[1] = 8'h3C;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R9 restart match", int'(a), 1);
    send_byte(8'h04, a); send_byte(8'h01, a);
    send_byte(8'hC3, a); model[4] = 8'hC3;
    bus_stop();
    chk_bank("R9 mid-write restart");
    bus_start();
    send_byte(8'h10, a);
    bus_start();
    send_byte(8'hD2, a); chk(a, "R9 after foreign", int'(a), 1);
    send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'h81, a); model[0] = 8'h81;
    bus_stop();
    chk_bank("R9 write after foreign");

    // R8 stop after index, then after count
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h02, a);
    bus_stop();
    chk(sda_oe == 1'b0, "R8 idle after stop", int'(sda_oe), 0);
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h02, a); send_byte(8'h02, a);
    bus_stop();
    chk_bank("R8 nothing stored");
    wr_txn(3, 2, 2, "R8 transfer after stops");
    rd_txn(0, NR, "R8 readback");

    chk(drive_viol == 0, "R10 drive only while clock low", drive_viol, 0);
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule